// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs one read or write cycle at a time on an external asynchronous static memory or ROM bank. It drives the address bus with an address-drive qualifier, an active-low chip select, an active-low output enable and an active-low write enable. The shape of each cycle comes from a 12-bit timing word. That word sets five phases in this order: address setup, chip-select setup, access, chip-select hold and address hold. It also holds a bit that lets an external wait pin stretch the access phase.

A request enters on a valid/ready port. `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high, and the timing word, address, direction and write data are captured on that edge. While a cycle runs, `req_ready` stays low and a held `req_valid` is not taken. The response port has no back-pressure. `rsp_valid` is high for exactly one clock, and `rsp_rdata` holds its value until the next read completes. The consumer must take the response in that clock.

Top module: `smem_strobe_seq`

## Requirements
- R1: After reset, `req_ready`=1, `mem_addr_en`=0, `mem_cs_n`=1, `mem_oe_n`=1, `mem_we_n`=1 and `rsp_valid`=0.
- R2: `req_ready` is 1 only in idle. A request transfers when `req_valid` and `req_ready` are both 1, and `req_valid` held during a running cycle starts nothing.
- R3: Timing word bits [1:0] set the address setup phase. Codes 0, 1, 2 and 3 give 0, 1, 2 and 4 clocks in which `mem_addr_en`=1, `mem_cs_n`=1 and both strobes are high. The first cycle after acceptance belongs to the first phase that has a nonzero length.
- R4: Bits [3:2] set the chip-select setup phase with the same 0/1/2/4 mapping. During it `mem_cs_n`=0 and both strobes are high.
- R5: Bits [6:4] set the access phase. Codes 0 to 7 give 1, 2, 3, 4, 6, 8, 10 and 14 clocks in which `mem_cs_n`=0 and the strobe for the cycle's direction is low.
- R6: A read (`req_write`=0) drives `mem_oe_n` low during access and a write drives `mem_we_n` low, with identical timing. During a write's access phase `mem_wdata` equals the accepted write data.
- R7: Bits [8:7] set the chip-select hold phase after the strobe is released, with the 0/1/2/4 mapping. `mem_cs_n` stays 0 during it.
- R8: Bits [10:9] set the address hold phase after chip select is released, with the 0/1/2/4 mapping. `mem_addr_en`=1 and `mem_cs_n`=1 during it.
- R9: With bit [11]=1, `mem_wait` is sampled only in the last access clock. While it is 1 there, access extends by one clock and is sampled again. A wait that falls before that clock has no effect, and with bit [11]=0 the pin is ignored.
- R10: For a read, `rsp_rdata` takes the value of `mem_rdata` from the final access clock. A write leaves `rsp_rdata` unchanged.
- R11: `rsp_valid` is 1 for exactly one clock, in the cycle right after address hold ends, with `mem_addr_en`=0 and `mem_cs_n`=1. `req_ready` returns to 1 on the following clock.
- R12: The timing word and request fields are used as captured at acceptance. Changing them during a cycle alters neither the timing nor `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 12 | Bank timing word, captured at request acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Last read data |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_addr_en | output | 1 | Address bus driven |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_wait | input | 1 | External wait, active high |

## Verification
The hardest case to reach from the ports is the wait sample landing exactly on the last access clock. A wait that starts early and falls one clock before that point must add nothing, and one still high there must add clocks one at a time. The stimulus asserts `mem_wait` for a chosen number of clocks counted from acceptance, and places that window before, on and past the nominal end of access. It also changes `mem_rdata` every clock, so the captured value shows which clock the access really ended in. Busy-time requests are reached by holding `req_valid` high and scrambling the timing word during a running cycle.

// File: rtl/smem_timing_pkg.sv
package smem_timing_pkg;

  localparam int CFG_W   = 12;
  localparam int CNT_W   = 4;
  localparam int N_TIMED = 5;
  localparam int N_SHORT = 4;

  // index of each timed phase in the decoded length vector
  localparam int IX_ASU = 0;
  localparam int IX_CSU = 1;
  localparam int IX_ACC = 2;
  localparam int IX_CSH = 3;
  localparam int IX_AH  = 4;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASU  = 3'd1,
    PH_CSU  = 3'd2,
    PH_ACC  = 3'd3,
    PH_CSH  = 3'd4,
    PH_AH   = 3'd5,
    PH_DONE = 3'd6
  } phase_e;

  typedef struct packed {
    logic       wait_en;  // [11]
    logic [1:0] ah;       // [10:9]
    logic [1:0] csh;      // [8:7]
    logic [2:0] acc;      // [6:4]
    logic [1:0] csu;      // [3:2]
    logic [1:0] asu;      // [1:0]
  } bank_cfg_t;

  localparam bank_cfg_t CFG_RESET = '{wait_en: 1'b0, ah: 2'd0, csh: 2'd0,
                                      acc: 3'd7, csu: 2'd0, asu: 2'd0};

  // setup/hold encoding: 0,1,2 are literal, 3 means four clocks
  function automatic logic [CNT_W-1:0] short_clocks(input logic [1:0] code);
    short_clocks = (code == 2'd3) ? CNT_W'(4) : CNT_W'(code);
  endfunction

  // access encoding: linear up to four, then steps of two, top code is 14
  function automatic logic [CNT_W-1:0] access_clocks(input logic [2:0] code);
    if (code < 3'd4)
      access_clocks = CNT_W'(code) + CNT_W'(1);
    else if (code == 3'd7)
      access_clocks = CNT_W'(14);
    else
      access_clocks = (CNT_W'(code) << 1) - CNT_W'(2);
  endfunction

endpackage

// File: rtl/smem_phase_decode.sv
module smem_phase_decode
  import smem_timing_pkg::*;
(
  input  bank_cfg_t                         cfg,
  output logic [N_TIMED-1:0][CNT_W-1:0]     plen
);

  logic [N_SHORT-1:0][1:0]       short_code;
  logic [N_SHORT-1:0][CNT_W-1:0] short_len;

  assign short_code = {cfg.ah, cfg.csh, cfg.csu, cfg.asu};

  for (genvar i = 0; i < N_SHORT; i++) begin : g_short
    assign short_len[i] = short_clocks(short_code[i]);
  end

  assign plen[IX_ASU] = short_len[0];
  assign plen[IX_CSU] = short_len[1];
  assign plen[IX_ACC] = access_clocks(cfg.acc);
  assign plen[IX_CSH] = short_len[2];
  assign plen[IX_AH]  = short_len[3];

endmodule

// File: rtl/smem_phase_fsm.sv
module smem_phase_fsm
  import smem_timing_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [N_TIMED-1:0][CNT_W-1:0] plen,
  input  logic                          stretch,
  output phase_e                        phase,
  output logic                          acc_last
);

  phase_e            st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              nz_asu, nz_csu, nz_csh, nz_ah;

  assign nz_asu = (plen[IX_ASU] != '0);
  assign nz_csu = (plen[IX_CSU] != '0);
  assign nz_csh = (plen[IX_CSH] != '0);
  assign nz_ah  = (plen[IX_AH]  != '0);

  function automatic logic [CNT_W-1:0] len_of(input phase_e p,
                                               input logic [N_TIMED-1:0][CNT_W-1:0] l);
    case (p)
      PH_ASU:  len_of = l[IX_ASU];
      PH_CSU:  len_of = l[IX_CSU];
      PH_ACC:  len_of = l[IX_ACC];
      PH_CSH:  len_of = l[IX_CSH];
      PH_AH:   len_of = l[IX_AH];
      default: len_of = CNT_W'(1);
    endcase
  endfunction

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    acc_last = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (start)
          st_n = nz_asu ? PH_ASU : (nz_csu ? PH_CSU : PH_ACC);
      end
      PH_ASU: begin
        if (cnt_q == '0) st_n = nz_csu ? PH_CSU : PH_ACC;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      PH_CSU: begin
        if (cnt_q == '0) st_n = PH_ACC;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      PH_ACC: begin
        if (cnt_q == '0) begin
          if (!stretch) begin
            acc_last = 1'b1;
            st_n     = nz_csh ? PH_CSH : (nz_ah ? PH_AH : PH_DONE);
          end
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      PH_CSH: begin
        if (cnt_q == '0) st_n = nz_ah ? PH_AH : PH_DONE;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      PH_AH: begin
        if (cnt_q == '0) st_n = PH_DONE;
        else             cnt_n = cnt_q - CNT_W'(1);
      end
      PH_DONE: st_n = PH_IDLE;
      default: st_n = PH_IDLE;
    endcase
    if (st_n != st_q)
      cnt_n = len_of(st_n, plen) - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign phase = st_q;

endmodule

// File: rtl/smem_bus_drive.sv
module smem_bus_drive
  import smem_timing_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            phase,
  input  logic              acc_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_en,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              wr_q;
  logic              in_cs, strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      if (acc_last && !wr_q)
        rdata_q <= mem_rdata;
    end
  end

  assign in_cs  = (phase == PH_CSU) || (phase == PH_ACC) || (phase == PH_CSH);
  assign strobe = (phase == PH_ACC);

  assign mem_addr_en = (phase == PH_ASU) || in_cs || (phase == PH_AH);
  assign mem_cs_n    = !in_cs;
  assign mem_oe_n    = !(strobe && !wr_q);
  assign mem_we_n    = !(strobe && wr_q);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign req_ready   = (phase == PH_IDLE);
  assign rsp_valid   = (phase == PH_DONE);
  assign rsp_rdata   = rdata_q;

endmodule

// File: rtl/smem_strobe_seq.sv
module smem_strobe_seq
  import smem_timing_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       cfg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_en,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_wait
);

  bank_cfg_t                     cfg_q, cfg_eff;
  logic [N_TIMED-1:0][CNT_W-1:0] plen;
  phase_e                        phase;
  logic                          accept, acc_last, stretch;

  assign accept  = req_valid && req_ready;
  assign cfg_eff = accept ? bank_cfg_t'(cfg_word) : cfg_q;
  assign stretch = cfg_q.wait_en && mem_wait;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (accept) cfg_q <= bank_cfg_t'(cfg_word);
  end

  smem_phase_decode u_dec (
    .cfg  (cfg_eff),
    .plen (plen)
  );

  smem_phase_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .plen     (plen),
    .stretch  (stretch),
    .phase    (phase),
    .acc_last (acc_last)
  );

  smem_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .phase       (phase),
    .acc_last    (acc_last),
    .mem_rdata   (mem_rdata),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .mem_addr    (mem_addr),
    .mem_addr_en (mem_addr_en),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_wdata   (mem_wdata)
  );

endmodule

// File: rtl/smem_strobe_seq_chk.sv
module smem_strobe_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_addr_en,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);

  p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_cs_in_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> mem_addr_en);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_addr_en));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_done_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && !mem_addr_en));

  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_en && $past(mem_addr_en)) |-> $stable(mem_addr));

endmodule

bind smem_strobe_seq smem_strobe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_smem_strobe_seq.sv
`timescale 1ns/1ps
module sim_smem_strobe_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr;
  logic        mem_addr_en;
  logic        mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_wait = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  smem_strobe_seq u0 (.*);

  typedef struct {
    logic aen, csn, oen, wen, done, rdy;
    int   tag;
  } exp_t;

  exp_t q[$];

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; 12: return "R12";
      default: return "R?";
    endcase
  endfunction

  function automatic int sclk(input int c);
    return (c == 3) ? 4 : c;
  endfunction

  function automatic int aclk(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 6;  5: return 8;  6: return 10; default: return 14;
    endcase
  endfunction

  function automatic logic [11:0] mk(input int asu, csu, acc, csh, ah, input logic wen);
    return {wen, 2'(ah), 2'(csh), 3'(acc), 2'(csu), 2'(asu)};
  endfunction

  task automatic chk(input string lbl, input int tag, input string fld,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", tname(tag), lbl, fld, act, exp);
    end
  endtask

  task automatic push(input int n, input logic aen, csn, oen, wen, done, rdy, input int tag);
    exp_t e;
    e.aen = aen; e.csn = csn; e.oen = oen; e.wen = wen;
    e.done = done; e.rdy = rdy; e.tag = tag;
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  task automatic run_txn(input string lbl, input logic [11:0] cfg, input logic wr,
                         input logic [15:0] addr, input logic [15:0] wdata,
                         input logic [15:0] base, input int wait_t,
                         input logic hold_valid, input logic scramble);
    int a, c, x, h, g, e, lastacc, k;
    logic soe, swe;
    logic [15:0] exp_rd;
    exp_t ent;
    a = sclk(int'(cfg[1:0]));
    c = sclk(int'(cfg[3:2]));
    x = aclk(int'(cfg[6:4]));
    h = sclk(int'(cfg[8:7]));
    g = sclk(int'(cfg[10:9]));
    e = a + c + x;
    lastacc = (cfg[11] && (wait_t + 1 > e)) ? wait_t + 1 : e;
    soe = wr ? 1'b1 : 1'b0;
    swe = wr ? 1'b0 : 1'b1;
    exp_rd = wr ? last_rd : base + 16'(lastacc);
    push(a, 1, 1, 1, 1, 0, 0, 3);
    push(c, 1, 0, 1, 1, 0, 0, 4);
    push(x, 1, 0, soe, swe, 0, 0, 5);
    push(lastacc - e, 1, 0, soe, swe, 0, 0, 9);
    push(h, 1, 0, 1, 1, 0, 0, 7);
    push(g, 1, 1, 1, 1, 0, 0, 8);
    push(1, 0, 1, 1, 1, 1, 0, 11);
    push(1, 0, 1, 1, 1, 0, 1, 11);

    @(negedge clk);
    cfg_word  = cfg;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = wdata;
    mem_wait  = 1'b0;
    mem_rdata = base;
    k = 1;
    while (q.size() > 0) begin
      @(negedge clk);
      ent = q.pop_front();
      chk(lbl, ent.tag, "addr_en", 16'(mem_addr_en), 16'(ent.aen));
      chk(lbl, ent.tag, "cs_n",    16'(mem_cs_n),    16'(ent.csn));
      chk(lbl, (ent.tag == 5) ? 6 : ent.tag, "oe_n", 16'(mem_oe_n), 16'(ent.oen));
      chk(lbl, (ent.tag == 5) ? 6 : ent.tag, "we_n", 16'(mem_we_n), 16'(ent.wen));
      chk(lbl, 11, "rsp_valid", 16'(rsp_valid), 16'(ent.done));
      chk(lbl, 2,  "req_ready", 16'(req_ready), 16'(ent.rdy));
      if (ent.aen) chk(lbl, 12, "mem_addr", mem_addr, addr);
      if (!ent.wen) chk(lbl, 6, "mem_wdata", mem_wdata, wdata);
      if (ent.done) chk(lbl, 10, "rsp_rdata", rsp_rdata, exp_rd);
      if (scramble) cfg_word = ~cfg;
      if (!hold_valid || ent.done || ent.rdy) req_valid = 1'b0;
      else begin
        req_addr  = ~addr;
        req_write = ~wr;
      end
      mem_wait  = (k <= wait_t);
      mem_rdata = base + 16'(k);
      k++;
    end
    req_valid = 1'b0;
    mem_wait  = 1'b0;
    cfg_word  = cfg;
    if (!wr) last_rd = exp_rd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset", 1, "req_ready", 16'(req_ready), 16'd1);
    chk("reset", 1, "addr_en",   16'(mem_addr_en), 16'd0);
    chk("reset", 1, "cs_n",      16'(mem_cs_n), 16'd1);
    chk("reset", 1, "oe_n",      16'(mem_oe_n), 16'd1);
    chk("reset", 1, "we_n",      16'(mem_we_n), 16'd1);
    chk("reset", 1, "rsp_valid", 16'(rsp_valid), 16'd0);

    // R5 shortest cycle, all setup/hold zero
    run_txn("min read",  mk(0,0,0,0,0,0), 1'b0, 16'h1234, 16'h0, 16'h1000, 0, 0, 0);
    // R3 R4 R7 R8 mixed lengths
    run_txn("mixed read", mk(1,2,3,3,1,0), 1'b0, 16'h2222, 16'h0, 16'h2000, 0, 0, 0);
    // R6 write with longest phases
    run_txn("long write", mk(3,3,7,2,3,0), 1'b1, 16'h3333, 16'hBEEF, 16'h3000, 0, 0, 0);
    // R10 write left read data untouched; read again
    run_txn("read after write", mk(2,1,1,1,2,0), 1'b0, 16'h4444, 16'h0, 16'h4000, 0, 0, 0);
    // R5 every access code, setup/hold codes varied
    for (int ac = 0; ac < 8; ac++)
      run_txn("access sweep", mk(ac % 4, (ac + 1) % 4, ac, (ac + 2) % 4, (ac + 3) % 4, 0),
              ac[0], 16'(16'h5000 + ac), 16'(16'hA000 + ac), 16'(16'h6000 + 16'h100 * ac), 0, 0, 0);
    // R9 wait held past the nominal end: access stretched
    run_txn("wait stretch", mk(1,1,1,0,1,1), 1'b0, 16'h7777, 16'h0, 16'h7000, 9, 0, 0);
    // R9 wait stretch on a write
    run_txn("wait stretch write", mk(0,1,2,1,0,1), 1'b1, 16'h7778, 16'h5A5A, 16'h7100, 7, 0, 0);
    // R9 wait high up to the clock before the last access clock: no effect
    run_txn("wait early drop", mk(1,1,4,1,1,1), 1'b0, 16'h8888, 16'h0, 16'h8000, 7, 0, 0);
    // R9 wait high exactly through the last access clock: one extra clock
    run_txn("wait one extra", mk(1,1,4,1,1,1), 1'b0, 16'h8889, 16'h0, 16'h8100, 8, 0, 0);
    // R9 wait pin ignored when the enable bit is clear
    run_txn("wait disabled", mk(0,0,2,0,0,0), 1'b0, 16'h9999, 16'h0, 16'h9000, 30, 0, 0);
    // R2 R12 request held and timing word scrambled while busy
    run_txn("R2 R12 busy hold", mk(2,0,3,1,3,0), 1'b0, 16'hABCD, 16'h0, 16'hB000, 0, 1, 1);
    run_txn("R2 R12 busy write", mk(0,2,5,3,0,0), 1'b1, 16'hCDEF, 16'h1111, 16'hC000, 0, 1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule